// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This unit sits between an interrupt arbiter and the CPU interfaces of an interrupt controller. When a CPU reads its acknowledge register, the unit takes the arbiter's current pending ID for that CPU. It compares that interrupt's priority against the CPU's running priority and either refuses with the spurious ID 1023 or accepts the interrupt. On acceptance it returns the ID, and for software-generated IDs it also returns the number of one requesting CPU. It then emits strobes that update the pending and source-bitmap storage, which is kept outside the unit.

Each CPU has its own stack of nested active interrupts. The stack is held as a linked chain: every interrupt ID stores the ID that was running when it was accepted. A completion (EOI) of the running ID pops the chain. A completion of an older, non-running ID starts a walk along the chain that splices that ID out, so software may complete interrupts out of order. While a walk is in progress the unit raises `busy` and accepts no new requests.

Top module: `irq_ack_unit`

## Requirements
- R1: An acknowledge that is refused returns 1023 and changes no running ID or priority. An acknowledge is refused when the pending ID is at or above NIRQ (no pending interrupt), or when the pending interrupt's priority is not strictly below the CPU's running priority. A refused acknowledge raises neither clear strobe.
- R2: An accepted acknowledge returns the ID in bits 9:0. It makes that ID the CPU's running ID and its 8-bit priority (running priority bit 8 = 0) the running priority. The previous running ID becomes the predecessor of the accepted ID.
- R3: For an accepted ID below 16, the unit selects the lowest-numbered set bit of `sgi_src`. It returns that bit's index in bits 12:10 of `ack_data` and signals only that bit on `src_clr_mask`, together with `src_clr`.
- R4: `pend_clr` (with `pend_clr_id`, `pend_clr_cpu`) pulses on every accepted acknowledge of an ID of 16 or more. For an ID below 16 it pulses only when `sgi_src` has no other bit set besides the selected one.
- R5: An EOI is ignored when its ID is at or above NIRQ, or when the CPU's running ID is 1023.
- R6: An EOI of the running ID restores the predecessor as running ID. The running priority becomes that ID's priority, or 0x100 when the restored ID is 1023.
- R7: An EOI of a non-running ID walks the chain from the running ID. The entry whose predecessor is the completed ID takes over the completed ID's predecessor. If 1023 is reached first, nothing changes. The running ID and priority do not change either way.
- R8: While `busy` is high (a walk in progress), acknowledge and EOI strobes are not taken: `ack_data` reads 1023, no clear strobe fires and no state changes.
- R9: When `ack_req` and `eoi_req` are high in the same cycle, the acknowledge is handled and the EOI is dropped.
- R10: After reset every running ID is 1023, every running priority is 0x100, every predecessor is 1023 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_req | input | 1 | Acknowledge read strobe |
| ack_cpu | input | CW | CPU issuing the acknowledge |
| pend_id | input | 10 | Arbiter's highest pending ID for `ack_cpu` (1023 = none) |
| sgi_src | input | NCPU | Source bitmap of `pend_id` for `ack_cpu` when it is below 16 |
| prio_tbl | input | NIRQ*PW | Priority of each ID, ID n at bits n*PW +: PW |
| ack_data | output | 32 | Acknowledge result, valid in the strobe cycle |
| pend_clr | output | 1 | Clear pending flag strobe |
| pend_clr_id | output | 10 | ID whose pending flag is cleared |
| pend_clr_cpu | output | CW | CPU whose pending flag is cleared |
| src_clr | output | 1 | Clear one source bit strobe |
| src_clr_mask | output | NCPU | One-hot source bit to clear |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_cpu | input | CW | CPU issuing the EOI |
| eoi_id | input | 10 | Completed ID |
| busy | output | 1 | Chain walk in progress |
| run_id_o | output | NCPU*10 | Running ID per CPU |
| run_prio_o | output | NCPU*(PW+1) | Running priority per CPU |

## Verification
The bench builds the unit with NCPU=2, NIRQ=48 and PW=8. With two CPUs, a two-bit source bitmap can show both the lowest-bit choice and the last-source retirement of a software interrupt. Two CPUs also allow an acknowledge on one CPU while the other CPU is walking, or while it issues a colliding EOI. With 48 IDs, an EOI of 48 lands exactly on the range limit. Three-deep nesting on one CPU covers a pop, a splice in the middle of the chain, a two-step walk that splices at the bottom of the chain, and a walk that finds nothing.

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
  parameter int NCPU = 2,
  parameter int NIRQ = 64,
  parameter int PW   = 8,
  localparam int CW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ack_req,
  input  logic [CW-1:0]          ack_cpu,
  input  logic [9:0]             pend_id,
  input  logic [NCPU-1:0]        sgi_src,
  input  logic [NIRQ*PW-1:0]     prio_tbl,
  output logic [31:0]            ack_data,
  output logic                   pend_clr,
  output logic [9:0]             pend_clr_id,
  output logic [CW-1:0]          pend_clr_cpu,
  output logic                   src_clr,
  output logic [NCPU-1:0]        src_clr_mask,
  input  logic                   eoi_req,
  input  logic [CW-1:0]          eoi_cpu,
  input  logic [9:0]             eoi_id,
  output logic                   busy,
  output logic [NCPU*10-1:0]     run_id_o,
  output logic [NCPU*(PW+1)-1:0] run_prio_o
);
  localparam int IW = $clog2(NIRQ);
  localparam logic [9:0] IDLE = 10'd1023;
  localparam logic [PW:0] NOPRIO = {1'b1, {PW{1'b0}}};

  logic [9:0]  pred     [NCPU][NIRQ];
  logic [9:0]  run_id   [NCPU];
  logic [PW:0] run_prio [NCPU];

  logic          walking;
  logic [CW-1:0] w_cpu;
  logic [9:0]    w_id, w_tmp, w_nxt;

  function automatic logic [PW:0] rprio(input logic [9:0] id);
    if (id == IDLE) return NOPRIO;
    return {1'b0, prio_tbl[int'(id[IW-1:0])*PW +: PW]};
  endfunction

  logic [PW-1:0]   pp;
  logic            pid_ok, is_sgi, ack_ok;
  logic [2:0]      src_sel;
  logic [NCPU-1:0] src_hot;

  assign busy   = walking;
  assign pid_ok = pend_id < 10'(NIRQ);
  assign pp     = prio_tbl[int'(pend_id[IW-1:0])*PW +: PW];
  assign is_sgi = pend_id < 10'd16;
  assign ack_ok = ack_req && !walking && pid_ok && ({1'b0, pp} < run_prio[ack_cpu]);

  always_comb begin
    src_sel = 3'd0;
    src_hot = '0;
    for (int i = NCPU-1; i >= 0; i--) begin
      if (sgi_src[i]) begin
        src_sel = 3'(i);
        src_hot = NCPU'(1) << i;
      end
    end
  end

  assign ack_data     = ack_ok ? {19'd0, (is_sgi ? src_sel : 3'd0), pend_id} : 32'd1023;
  assign pend_clr     = ack_ok && (!is_sgi || ((sgi_src & ~src_hot) == '0));
  assign pend_clr_id  = pend_id;
  assign pend_clr_cpu = ack_cpu;
  assign src_clr      = ack_ok && is_sgi;
  assign src_clr_mask = src_clr ? src_hot : '0;

  logic       eoi_go, eoi_pop, eoi_walk;
  logic [9:0] pop_id;

  assign eoi_go   = eoi_req && !ack_req && !walking && (eoi_id < 10'(NIRQ)) && (run_id[eoi_cpu] != IDLE);
  assign eoi_pop  = eoi_go && (eoi_id == run_id[eoi_cpu]);
  assign eoi_walk = eoi_go && !eoi_pop;
  assign pop_id   = pred[eoi_cpu][eoi_id[IW-1:0]];
  assign w_nxt    = pred[w_cpu][w_tmp[IW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++) begin
        run_id[c]   <= IDLE;
        run_prio[c] <= NOPRIO;
        for (int i = 0; i < NIRQ; i++) pred[c][i] <= IDLE;
      end
      walking <= 1'b0;
      w_cpu   <= '0;
      w_id    <= IDLE;
      w_tmp   <= IDLE;
    end else begin
      if (ack_ok) begin
        pred[ack_cpu][pend_id[IW-1:0]] <= run_id[ack_cpu];
        run_id[ack_cpu]   <= pend_id;
        run_prio[ack_cpu] <= {1'b0, pp};
      end
      if (eoi_pop) begin
        run_id[eoi_cpu]   <= pop_id;
        run_prio[eoi_cpu] <= rprio(pop_id);
      end
      if (eoi_walk) begin
        walking <= 1'b1;
        w_cpu   <= eoi_cpu;
        w_id    <= eoi_id;
        w_tmp   <= run_id[eoi_cpu];
      end
      if (walking) begin
        if (w_nxt == IDLE) begin
          walking <= 1'b0;
        end else if (w_nxt == w_id) begin
          pred[w_cpu][w_tmp[IW-1:0]] <= pred[w_cpu][w_id[IW-1:0]];
          walking <= 1'b0;
        end else begin
          w_tmp <= w_nxt;
        end
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_out
    assign run_id_o[c*10 +: 10]         = run_id[c];
    assign run_prio_o[c*(PW+1) +: PW+1] = run_prio[c];

    // R6
    idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_id[c] == IDLE) == (run_prio[c] == NOPRIO));

    // R2
    rp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !busy && ack_cpu == CW'(c) && ack_data != 32'd1023)
      |=> run_prio[c] < $past(run_prio[c]));
  end

  // R1
  rej_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !busy && ack_data == 32'd1023) |=> ($stable(run_id_o) && $stable(run_prio_o)));

  // R3
  src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_clr_mask));

  // R8
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!pend_clr && !src_clr && ack_data == 32'd1023));

  // R5
  eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && !ack_req && !busy && run_id_o[eoi_cpu*10 +: 10] == IDLE)
    |=> (!busy && $stable(run_id_o)));
endmodule

// File: tb/test_irq_ack_unit.sv
module test_irq_ack_unit;
  localparam int NCPU = 2, NIRQ = 48, PW = 8, CW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ack_req = 1'b0, eoi_req = 1'b0;
  logic [CW-1:0] ack_cpu = '0, eoi_cpu = '0, pend_clr_cpu;
  logic [9:0] pend_id = 10'd1023, eoi_id = 10'd0, pend_clr_id;
  logic [NCPU-1:0] sgi_src = '0, src_clr_mask;
  logic [NIRQ*PW-1:0] prio_tbl = '1;
  logic [31:0] ack_data;
  logic pend_clr, src_clr, busy;
  logic [NCPU*10-1:0] run_id_o;
  logic [NCPU*(PW+1)-1:0] run_prio_o;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  irq_ack_unit #(.NCPU(NCPU), .NIRQ(NIRQ), .PW(PW)) i_irq_ack_unit (
    .clk, .rst_n, .ack_req, .ack_cpu, .pend_id, .sgi_src, .prio_tbl, .ack_data,
    .pend_clr, .pend_clr_id, .pend_clr_cpu, .src_clr, .src_clr_mask,
    .eoi_req, .eoi_cpu, .eoi_id, .busy, .run_id_o, .run_prio_o);

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rid(int c);  return int'(run_id_o[c*10 +: 10]); endfunction
  function automatic int rpr(int c);  return int'(run_prio_o[c*9 +: 9]); endfunction

  task automatic ack(int cpu, int id, int src, int exp_data, int exp_pc, int exp_mask, string req);
    ack_cpu = CW'(cpu); pend_id = 10'(id); sgi_src = NCPU'(src); ack_req = 1'b1;
    #1;
    check({req, " ack_data"}, int'(ack_data), exp_data);
    check({req, " pend_clr"}, int'(pend_clr), exp_pc);
    check({req, " src_mask"}, int'(src_clr_mask), exp_mask);
    @(negedge clk);
    ack_req = 1'b0; pend_id = 10'd1023; sgi_src = '0;
  endtask

  task automatic eoi(int cpu, int id);
    eoi_cpu = CW'(cpu); eoi_id = 10'(id); eoi_req = 1'b1;
    @(negedge clk);
    eoi_req = 1'b0;
    for (int k = 0; k < 100 && busy; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 run0", rid(0), 1023);
    check("R10 run1", rid(1), 1023);
    check("R10 prio0", rpr(0), 256);
    check("R10 prio1", rpr(1), 256);
    check("R10 busy", int'(busy), 0);
    ack(0, 1023, 0, 1023, 0, 0, "R1 none");
    ack(0, 47 + 975, 0, 1023, 0, 0, "R1 outofrange");
    check("R1 run0 kept", rid(0), 1023);
  endtask

  task automatic t_nest;
    ack(0, 20, 0, 20, 1, 0, "R2 R4 id20");
    check("R2 run0", rid(0), 20);
    check("R2 prio0", rpr(0), 'h80);
    ack(0, 40, 0, 1023, 0, 0, "R1 equal prio");
    check("R1 run0 kept", rid(0), 20);
    check("R1 prio0 kept", rpr(0), 'h80);
    ack(0, 30, 0, 30, 1, 0, "R2 id30");
    ack(0, 35, 0, 35, 1, 0, "R2 id35");
    check("R2 prio0 nested", rpr(0), 'h20);
  endtask

  task automatic t_deep_walk;
    t_nest;
    eoi(0, 20);
    check("R7 run kept", rid(0), 35);
    check("R7 prio kept", rpr(0), 'h20);
    eoi(0, 35);
    check("R6 pop run", rid(0), 30);
    check("R6 pop prio", rpr(0), 'h40);
    eoi(0, 30);
    check("R6 idle run", rid(0), 1023);
    check("R6 idle prio", rpr(0), 256);
  endtask

  task automatic t_mid_splice;
    setp(40, 'h90);
    ack(0, 20, 0, 20, 1, 0, "R2 id20");
    ack(0, 30, 0, 30, 1, 0, "R2 id30");
    ack(0, 35, 0, 35, 1, 0, "R2 id35");
    eoi(0, 30);
    check("R7 mid run", rid(0), 35);
    eoi(0, 35);
    check("R7 spliced run", rid(0), 20);
    check("R7 spliced prio", rpr(0), 'h80);
    eoi(0, 20);
    check("R6 empty", rid(0), 1023);
    setp(40, 'h80);
  endtask

  task automatic t_ignored;
    ack(0, 20, 0, 20, 1, 0, "R2 id20");
    eoi(0, 25);
    check("R7 notfound run", rid(0), 20);
    eoi(0, 35);
    eoi(0, 20);
    check("R7 notfound chain", rid(0), 1023);
    ack(0, 20, 0, 20, 1, 0, "R2 id20 again");
    eoi_cpu = 1'b0; eoi_id = 10'd48; eoi_req = 1'b1;
    @(negedge clk);
    eoi_req = 1'b0;
    check("R5 range busy", int'(busy), 0);
    check("R5 range run", rid(0), 20);
    eoi(0, 1023);
    check("R5 spurious run", rid(0), 20);
    eoi(0, 20);
    check("R5 back idle", rid(0), 1023);
    eoi(0, 20);
    check("R5 idle eoi", rid(0), 1023);
    check("R5 idle busy", int'(busy), 0);
  endtask

  task automatic t_sgi;
    ack(1, 5, 3, 5, 0, 1, "R3 R4 two sources");
    check("R3 run1", rid(1), 5);
    check("R3 prio1", rpr(1), 'h60);
    eoi(1, 5);
    ack(1, 5, 2, 'h405, 1, 2, "R3 R4 last source");
    eoi(1, 5);
    check("R3 run1 idle", rid(1), 1023);
  endtask

  task automatic t_stall;
    ack(0, 20, 0, 20, 1, 0, "R2 id20");
    ack(0, 30, 0, 30, 1, 0, "R2 id30");
    ack(0, 35, 0, 35, 1, 0, "R2 id35");
    eoi_cpu = 1'b0; eoi_id = 10'd20; eoi_req = 1'b1;
    @(negedge clk);
    eoi_req = 1'b0;
    check("R8 busy", int'(busy), 1);
    ack(1, 40, 0, 1023, 0, 0, "R8 stalled ack");
    check("R8 run1", rid(1), 1023);
    for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    check("R8 walk done", int'(busy), 0);
    eoi(0, 35);
    eoi(0, 30);
    check("R8 cleanup", rid(0), 1023);
  endtask

  task automatic t_collide;
    ack(0, 20, 0, 20, 1, 0, "R2 id20");
    eoi_cpu = 1'b0; eoi_id = 10'd20; eoi_req = 1'b1;
    ack(1, 40, 0, 40, 1, 0, "R9 ack wins");
    eoi_req = 1'b0;
    check("R9 eoi dropped", rid(0), 20);
    check("R9 ack taken", rid(1), 40);
    eoi(0, 20);
    eoi(1, 40);
    check("R9 cleanup", rid(0) + rid(1), 2046);
  endtask

  task automatic setp(int id, int v);
    prio_tbl[id*PW +: PW] = PW'(v);
  endtask

  initial begin
    setp(20, 'h80); setp(30, 'h40); setp(35, 'h20); setp(40, 'h80);
    setp(5, 'h60); setp(25, 'h10);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_deep_walk;
    t_mid_splice;
    t_ignored;
    t_sgi;
    t_stall;
    setp(40, 'h30);
    t_collide;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule